// File: doc/BRIEF.md
# Cascaded SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from a fast reference clock. It cascades two 4-bit stages. The first is a linear counter that divides by `pre_sel + 1`. Its one-cycle strobes feed a second counter that passes one strobe in every `2^post_sel`. The division ratio is therefore N = (pre_sel + 1) · 2^post_sel reference cycles. It runs from 1 (both settings zero) up to 16 · 32768. The settings come from the control register, which lies outside this block.

The main output `edge_tick` is a one-cycle strobe that fires once every N cycles. A shifter uses it to place both the launch edge and the sample edge, so the tick runs at twice the bit rate. The block also drives `sclk_out`, a bit-clock level that flips after every tick. Deasserting `run_en` parks `sclk_out` at `sclk_idle`, and no ticks are produced. Pulsing `resync`, or changing either setting, resets both counters so that the next full period starts from zero. Choosing the settings for a requested bit rate is done by software and is not part of this block.

Top module: `spi_clkdiv`

## Requirements
- R1: While enabled and settled, consecutive `edge_tick` pulses are exactly N = (pre_sel+1)·2^post_sel reference cycles apart, for pre_sel and post_sel each in 0..15.
- R2: With settings held, after `run_en` is first sampled high, the first `edge_tick` is high in the (N+1)th cycle, counting the cycle in which `run_en` was sampled as the first.
- R3: With pre_sel = 0 and post_sel = 0, `edge_tick` stays high on every reference cycle once it has started.
- R4: For N > 1, `edge_tick` is high for exactly one cycle per period.
- R5: `sclk_out` starts at `sclk_idle` and inverts in the cycle after each `edge_tick`. It never changes at any other time while enabled.
- R6: While `run_en` is low, `edge_tick` is low, and `sclk_out` equals `sclk_idle` one cycle later. A change of `sclk_idle` is followed there.
- R7: A one-cycle `resync` pulse clears both counters and returns `sclk_out` to idle. The next `edge_tick` is then high in the (N+2)th cycle, counting the pulse cycle as the first.
- R8: A change of `pre_sel` or `post_sel` acts as a resync. The next tick follows the new ratio and arrives N_new+2 cycles after the change, counted the same way.
- R9: The largest post setting (post_sel = 15, pre_sel = 0) gives a spacing of 32768 cycles, with no counter overflow.
- R10: While synchronous `rst` is high, `edge_tick` is low and `sclk_out` equals `sclk_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Divider enable |
| resync | input | 1 | One-cycle counter restart |
| sclk_idle | input | 1 | Level of sclk_out when idle |
| pre_sel | input | 4 | Linear stage setting, divides by pre_sel+1 |
| post_sel | input | 4 | Power-of-two stage setting, divides by 2^post_sel |
| edge_tick | output | 1 | One-cycle strobe every N reference cycles |
| sclk_out | output | 1 | Bit-clock level, inverted after each tick |

## Verification
The bench builds the block with its default widths: a 4-bit pre field and a 4-bit post field, which gives a 15-bit power-of-two counter. These widths put the whole setting range within reach. They cover the ratio-one corner, where the tick never drops, and linear-only, binary-only and mixed ratios, including two settings with the same product. They also cover the largest post setting at 32768 cycles, which exercises the top bit of the binary counter. Restart timing is measured to the exact cycle, both for a resync pulse and for a mid-period settings change, and an idle-high bit clock is covered as well.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  localparam int unsigned PRE_W_DEF  = 4;
  localparam int unsigned POST_W_DEF = 4;

  // Width of the power-of-two counter for a given post field width.
  function automatic int unsigned post_cnt_width(input int unsigned post_w);
    return (1 << post_w) - 1;
  endfunction

  // Reference cycles between ticks for given settings.
  function automatic longint unsigned div_ratio(input int unsigned pre_v,
                                                input int unsigned post_v);
    return (longint'(pre_v) + 1) << post_v;
  endfunction

endpackage

// File: rtl/spi_clkdiv_cfg_watch.sv
module spi_clkdiv_cfg_watch #(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              resync,
  input  logic [PRE_W-1:0]  pre_sel,
  input  logic [POST_W-1:0] post_sel,
  output logic              clr
);

  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic              moved;

  // Track the settings every cycle, including during reset, so that the
  // first cycle after reset does not see a spurious change.
  always_ff @(posedge clk) begin
    pre_q  <= pre_sel;
    post_q <= post_sel;
  end

  always_comb begin
    moved = (pre_sel != pre_q) || (post_sel != post_q);
    clr   = rst || !run_en || resync || moved;
  end

endmodule

// File: rtl/spi_clkdiv_pre_stage.sv
module spi_clkdiv_pre_stage #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             pre_tick
);

  logic [PRE_W-1:0] cnt;
  logic             at_end;

  always_comb at_end = (cnt == pre_sel);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt      <= '0;
      pre_tick <= 1'b0;
    end else if (at_end) begin
      cnt      <= '0;
      pre_tick <= 1'b1;
    end else begin
      cnt      <= cnt + 1'b1;
      pre_tick <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_clkdiv_post_stage.sv
module spi_clkdiv_post_stage #(
  parameter int unsigned POST_W = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              pre_tick,
  input  logic [POST_W-1:0] post_sel,
  output logic              tick
);

  localparam int unsigned CNT_W = (1 << POST_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   one_hot;
  logic [CNT_W:0]   term;
  logic             at_end;

  // Terminal count is 2^post_sel - 1, computed rather than tabulated.
  always_comb begin
    one_hot = (CNT_W+1)'(1) << post_sel;
    term    = one_hot - (CNT_W+1)'(1);
    at_end  = (cnt == term[CNT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (pre_tick) begin
      if (at_end) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_clkdiv_level.sv
module spi_clkdiv_level (
  input  logic clk,
  input  logic clr,
  input  logic idle_lvl,
  input  logic tick,
  output logic lvl
);

  always_ff @(posedge clk) begin
    if (clr)       lvl <= idle_lvl;
    else if (tick) lvl <= ~lvl;
  end

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_clkdiv_pkg::*;
#(
  parameter int unsigned PRE_W  = PRE_W_DEF,
  parameter int unsigned POST_W = POST_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              resync,
  input  logic              sclk_idle,
  input  logic [PRE_W-1:0]  pre_sel,
  input  logic [POST_W-1:0] post_sel,
  output logic              edge_tick,
  output logic              sclk_out
);

  logic clr;
  logic pre_tick;

  spi_clkdiv_cfg_watch #(.PRE_W(PRE_W), .POST_W(POST_W)) u_watch (
    .clk(clk), .rst(rst), .run_en(run_en), .resync(resync),
    .pre_sel(pre_sel), .post_sel(post_sel), .clr(clr)
  );

  spi_clkdiv_pre_stage #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .clr(clr), .pre_sel(pre_sel), .pre_tick(pre_tick)
  );

  spi_clkdiv_post_stage #(.POST_W(POST_W)) u_post (
    .clk(clk), .clr(clr), .pre_tick(pre_tick), .post_sel(post_sel),
    .tick(edge_tick)
  );

  spi_clkdiv_level u_lvl (
    .clk(clk), .clr(clr), .idle_lvl(sclk_idle), .tick(edge_tick),
    .lvl(sclk_out)
  );

endmodule

// File: rtl/spi_clkdiv_chk.sv
module spi_clkdiv_chk
  import spi_clkdiv_pkg::*;
#(
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned POST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              resync,
  input logic              sclk_idle,
  input logic [PRE_W-1:0]  pre_sel,
  input logic [POST_W-1:0] post_sel,
  input logic              edge_tick,
  input logic              sclk_out
);

  logic [PRE_W-1:0]  p_q;
  logic [POST_W-1:0] q_q;
  logic              moved;
  logic              gap_ok;
  longint unsigned   gap;
  longint unsigned   ratio;

  always_ff @(posedge clk) begin
    p_q <= pre_sel;
    q_q <= post_sel;
  end

  always_comb begin
    moved = (pre_sel != p_q) || (post_sel != q_q);
    ratio = div_ratio(int'(pre_sel), int'(post_sel));
  end

  // Cycle counter between ticks, restarted by anything that clears the block.
  always_ff @(posedge clk) begin
    if (rst || !run_en || resync || moved) begin
      gap_ok <= 1'b0;
      gap    <= 0;
    end else if (edge_tick) begin
      gap_ok <= 1'b1;
      gap    <= 1;
    end else begin
      gap <= gap + 1;
    end
  end

  a_r1_period: assert property (@(posedge clk) disable iff (rst)
    (edge_tick && gap_ok && !moved) |-> (gap == ratio));

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !edge_tick);

  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (sclk_out == $past(sclk_idle)));

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    resync |=> (!edge_tick && sclk_out == $past(sclk_idle)));

  a_r5_sclk_follows_tick: assert property (@(posedge clk) disable iff (rst)
    (run_en && !resync && !moved) |=> ((sclk_out != $past(sclk_out)) == $past(edge_tick)));

  a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (run_en && !resync && !moved && pre_sel == '0 && post_sel == '0 && edge_tick) |=> edge_tick);

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (run_en && !resync && !moved && edge_tick && !(pre_sel == '0 && post_sel == '0)) |=> !edge_tick);

endmodule

bind spi_clkdiv spi_clkdiv_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .resync(resync), .sclk_idle(sclk_idle),
  .pre_sel(pre_sel), .post_sel(post_sel), .edge_tick(edge_tick), .sclk_out(sclk_out)
);

// File: tb/test_spi_clkdiv.sv
module test_spi_clkdiv;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic       resync = 1'b0;
  logic       sclk_idle = 1'b0;
  logic [3:0] pre_sel = '0;
  logic [3:0] post_sel = '0;
  logic       edge_tick;
  logic       sclk_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_clkdiv i_spi_clkdiv (
    .clk(clk), .rst(rst), .run_en(run_en), .resync(resync), .sclk_idle(sclk_idle),
    .pre_sel(pre_sel), .post_sel(post_sel), .edge_tick(edge_tick), .sclk_out(sclk_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait until a tick is seen at a falling edge; returns the number of
  // falling edges waited.
  task automatic wait_tick(input longint lim, output longint cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!edge_tick && cnt < lim);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(edge_tick == 1'b0, "R10 tick in reset", edge_tick, 0);
    chk(sclk_out == sclk_idle, "R10 sclk in reset", sclk_out, sclk_idle);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disabled();
    bit seen = 1'b0;
    run_en = 1'b0;
    pre_sel = 4'd0; post_sel = 4'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (edge_tick) seen = 1'b1;
    end
    chk(!seen, "R6 no tick while off", seen, 0);
    sclk_idle = 1'b1;
    @(negedge clk);
    chk(sclk_out == 1'b1, "R6 idle level followed", sclk_out, 1);
    sclk_idle = 1'b0;
    @(negedge clk);
    chk(sclk_out == 1'b0, "R6 idle level followed", sclk_out, 0);
  endtask

  task automatic t_ratio(input int p, input int q, input int periods, input string tag);
    longint n   = (longint'(p) + 1) << q;
    longint cnt;
    logic   lvl = sclk_idle;
    run_en = 1'b0;
    pre_sel = 4'(p); post_sel = 4'(q);
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    wait_tick(n + 5, cnt);
    chk(cnt == n + 1, {"R2 first tick ", tag}, cnt, n + 1);
    chk(sclk_out == sclk_idle, {"R5 sclk starts idle ", tag}, sclk_out, sclk_idle);
    for (int k = 0; k < periods; k++) begin
      @(negedge clk);
      lvl = ~lvl;
      chk(sclk_out == lvl, {"R5 sclk toggle ", tag}, sclk_out, lvl);
      if (n > 1) chk(edge_tick == 1'b0, {"R4 tick width ", tag}, edge_tick, 0);
      cnt = 1;
      if (!edge_tick) begin
        wait_tick(n + 5, cnt);
        cnt++;
      end
      chk(cnt == n, {"R1 period ", tag}, cnt, n);
    end
    run_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fastest();
    longint cnt;
    bit     gap = 1'b0;
    run_en = 1'b0;
    pre_sel = 4'd0; post_sel = 4'd0;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    wait_tick(6, cnt);
    chk(cnt == 2, "R3 first tick", cnt, 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!edge_tick) gap = 1'b1;
    end
    chk(!gap, "R3 tick every cycle", gap, 0);
    run_en = 1'b0;
    @(negedge clk);
    chk(edge_tick == 1'b0, "R6 tick stops when off", edge_tick, 0);
  endtask

  task automatic t_restart(input int p, input int q);
    longint n = (longint'(p) + 1) << q;
    longint cnt;
    run_en = 1'b0;
    pre_sel = 4'(p); post_sel = 4'(q);
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    wait_tick(n + 5, cnt);
    repeat (3) @(negedge clk);
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    chk(edge_tick == 1'b0, "R7 tick cleared", edge_tick, 0);
    chk(sclk_out == sclk_idle, "R7 sclk to idle", sclk_out, sclk_idle);
    wait_tick(n + 5, cnt);
    cnt++;
    chk(cnt == n + 2, "R7 tick after resync", cnt, n + 2);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_cfg_change();
    longint n_new = (longint'(5) + 1) << 0;
    longint cnt;
    run_en = 1'b0;
    pre_sel = 4'd1; post_sel = 4'd2;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    wait_tick(20, cnt);
    repeat (2) @(negedge clk);
    pre_sel = 4'd5; post_sel = 4'd0;
    wait_tick(n_new + 5, cnt);
    chk(cnt == n_new + 2, "R8 tick after change", cnt, n_new + 2);
    @(negedge clk);
    wait_tick(n_new + 5, cnt);
    cnt++;
    chk(cnt == n_new, "R8 new period", cnt, n_new);
    run_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_fastest();
    t_ratio(3, 2, 3, "p3q2");
    t_ratio(15, 0, 3, "p15q0");
    t_ratio(0, 4, 3, "p0q4");
    t_ratio(2, 3, 3, "p2q3");
    t_ratio(1, 1, 3, "p1q1");
    sclk_idle = 1'b1;
    t_ratio(2, 1, 3, "idle high");
    sclk_idle = 1'b0;
    t_restart(4, 1);
    t_cfg_change();
    t_ratio(0, 15, 1, "R9 max post");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule